// File: doc/BRIEF.md
# I2C DAC Channel Readback Sequencer

This block is the master side of an I2C bus that fetches the contents of one channel's input register from a four-channel DAC. A single request pulse carries the 7-bit device address, a one-hot channel select and a choice of filler pattern. The block first runs a write transfer that tells the DAC which register to return. It sends the address with the direction bit cleared, then a command byte made of the readback opcode and the channel code, then two filler bytes. Without releasing the bus, it issues a repeated START, addresses the device again for reading, and clocks in two bytes.

The bus lines are modelled as open-drain pull-down enables. Bit timing is derived from a clock-enable tick, with four ticks per bit. Every acknowledge the slave owes is checked. A missing one aborts the transfer with a STOP and reports the index of the byte that failed. When the sequence ends, the 16-bit result is published together with a one-cycle completion pulse and an error flag.

Top module: `dac_rdbk_seq`

## Requirements
- R1: After reset both bus enables are low (lines released), `busy` and `done` are low, and the bus stays released whenever `busy` is low.
- R2: The write transfer is START, the byte {dev_addr, 0}, the command byte, then two filler bytes that are both 8'h00 when `dummy_ones` is 0 and both 8'hFF when it is 1. The slave must acknowledge every byte.
- R3: The command byte carries opcode 4'b1001 in bits 7:4 and the channel code in bits 3:0. The channel code is one-hot: 0001 selects A, 0010 selects B, 0100 selects C and 1000 selects D, so channel C gives 8'h94.
- R4: After the fourth byte is acknowledged, a repeated START follows with no STOP in between, then the byte {dev_addr, 1}. A complete transfer shows exactly two START conditions and one STOP condition.
- R5: Two bytes are read most significant first. The master drives ACK (SDA low) after the first and NACK (SDA released) after the second, and `rd_data` then holds the 16-bit value.
- R6: A request whose channel select does not have exactly one bit set produces no SCL edge and leaves `busy` low. One cycle later it gives a `done` pulse with `err` = 1 and `err_idx` = 7.
- R7: If the slave leaves SDA high in the acknowledge slot of byte k (0 = first address, 1 = command, 2 and 3 = filler, 4 = read address), a STOP follows at once. The transfer ends with `done`, `err` = 1 and `err_idx` = k, and `rd_data` is unchanged.
- R8: SDA changes only while SCL is low, except inside START (SDA falls with SCL high) and STOP (SDA rises with SCL high). Each bit, START and STOP takes four ticks, so a complete transfer has 66 SCL rising edges.
- R9: `busy` is high from an accepted request until the STOP completes. A request that arrives while `busy` is high is ignored.
- R10: `done` pulses for one clock after the STOP, never while `busy` is high. `rd_data` changes only at that pulse and holds its value between pulses, and a successful transfer returns `err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Bus timing enable, four per bit |
| start_req | input | 1 | One-cycle request pulse |
| dev_addr | input | 7 | Device address for the request |
| chan_sel | input | CHAN_W | One-hot channel select |
| dummy_ones | input | 1 | Filler bytes 8'hFF when 1, 8'h00 when 0 |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completion failed |
| err_idx | output | 3 | Failed byte index, 7 for a rejected request |
| rd_data | output | 16 | Last value read back |

## Verification
The bench aims at the places where a sequencer like this usually slips. A select with no bit or two bits set must not start the bus; a block that lets it through would clock out a command byte the slave cannot decode. Acknowledges are withheld at the first address, the command, a filler byte and the read address. A block that skipped any of those checks would run on into a read of garbage, overwrite `rd_data`, or report the wrong byte index. A second request is pushed in mid-transfer, where a careless block would swap its address or channel or emit an extra completion. The slave model also records the repeated START, the master's ACK and NACK on the read bytes, and the SCL edge count, which expose a STOP in place of the repeated START, an inverted last acknowledge, or a missing bit.

// File: rtl/dac_rdbk_pkg.sv
package dac_rdbk_pkg;
   // bus symbols executed by the line engine
   typedef enum logic [1:0] {
      SYM_START = 2'd0,
      SYM_STOP  = 2'd1,
      SYM_BIT   = 2'd2
   } sym_e;

   // sequencer phases
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_START = 2'd1,
      SQ_BIT   = 2'd2,
      SQ_STOP  = 2'd3
   } seq_e;

   localparam logic [2:0] LAST_BYTE  = 3'd6;  // second read byte
   localparam logic [2:0] RSTART_AT  = 3'd3;  // repeated start after this byte
   localparam logic [2:0] FIRST_RX   = 3'd5;
   localparam logic [2:0] REJECT_IDX = 3'd7;
endpackage

// File: rtl/i2c_sym_engine.sv
module i2c_sym_engine
   import dac_rdbk_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic cmd_valid,
   input  sym_e cmd,
   input  logic bit_out,
   input  logic sda_i,
   output logic ready,
   output logic sym_done,
   output logic bit_in,
   output logic scl_oe,
   output logic sda_oe
);
   logic       active_q;
   logic [1:0] ph_q;
   sym_e       cmd_q;
   logic       bit_q;
   logic       sda_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign sda_s = sda_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sy_q <= '1;
            else begin
               sy_q[0] <= sda_i;
               for (int i = 1; i < SYNC_STAGES; i++) sy_q[i] <= sy_q[i-1];
            end
         end
         assign sda_s = sy_q[SYNC_STAGES-1];
      end
   endgenerate

   // quarter 0: SCL low, 1: SDA set, 2: SCL released, 3: sample / edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         ph_q     <= 2'd0;
         cmd_q    <= SYM_STOP;
         bit_q    <= 1'b1;
         scl_oe   <= 1'b0;
         sda_oe   <= 1'b0;
         sym_done <= 1'b0;
         bit_in   <= 1'b1;
      end else begin
         sym_done <= 1'b0;
         if (!active_q) begin
            if (cmd_valid) begin
               active_q <= 1'b1;
               ph_q     <= 2'd0;
               cmd_q    <= cmd;
               bit_q    <= bit_out;
            end
         end else if (tick) begin
            ph_q <= ph_q + 2'd1;
            case (ph_q)
               2'd0: scl_oe <= 1'b1;
               2'd1: begin
                  if (cmd_q == SYM_START)     sda_oe <= 1'b0;
                  else if (cmd_q == SYM_STOP) sda_oe <= 1'b1;
                  else                        sda_oe <= !bit_q;
               end
               2'd2: scl_oe <= 1'b0;
               default: begin
                  active_q <= 1'b0;
                  sym_done <= 1'b1;
                  if (cmd_q == SYM_START)     sda_oe <= 1'b1;
                  else if (cmd_q == SYM_STOP) sda_oe <= 1'b0;
                  else                        bit_in <= sda_s;
               end
            endcase
         end
      end
   end

   assign ready = !active_q;

   // R8: a data bit never moves SDA while SCL is high
   assert_sda_moves_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !scl_oe && !$past(scl_oe)) |-> (cmd_q != SYM_BIT));

   // R8: a symbol completes only after its SCL high quarter
   assert_done_scl_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sym_done |-> !scl_oe);
endmodule

// File: rtl/dac_rdbk_ctrl.sv
module dac_rdbk_ctrl
   import dac_rdbk_pkg::*;
#(
   parameter int unsigned CHAN_W    = 4,
   parameter logic [3:0]  RD_OPCODE = 4'h9,
   parameter int unsigned ADDR_W    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [CHAN_W-1:0] chan_sel,
   input  logic              dummy_ones,
   input  logic              eng_ready,
   input  logic              sym_done,
   input  logic              bit_in,
   output logic              cmd_valid,
   output sym_e              cmd,
   output logic              bit_out,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [2:0]        err_idx,
   output logic [15:0]       rd_data
);
   localparam int unsigned DATA_W = 16;

   seq_e              st_q;
   logic              wait_q;
   logic [2:0]        byte_q;
   logic [3:0]        bit_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CHAN_W-1:0] chan_q;
   logic              dummy_q;
   logic [DATA_W-1:0] rx_q;
   logic              abort_q;
   logic [2:0]        fail_q;
   logic [7:0]        tx_byte;
   logic [3:0]        chan_nib;
   logic              is_rx;
   logic              ack_slot;

   assign chan_nib = 4'(chan_q);
   assign is_rx    = (byte_q >= FIRST_RX);
   assign ack_slot = (bit_q == 4'd8);

   always_comb begin
      case (byte_q)
         3'd0:    tx_byte = {addr_q, 1'b0};
         3'd1:    tx_byte = {RD_OPCODE, chan_nib};
         3'd2,
         3'd3:    tx_byte = {8{dummy_q}};
         default: tx_byte = {addr_q, 1'b1};
      endcase
   end

   always_comb begin
      if (!ack_slot) bit_out = is_rx ? 1'b1 : tx_byte[3'd7 - bit_q[2:0]];
      else           bit_out = is_rx ? (byte_q == LAST_BYTE) : 1'b1;
   end

   always_comb begin
      case (st_q)
         SQ_START: cmd = SYM_START;
         SQ_STOP:  cmd = SYM_STOP;
         default:  cmd = SYM_BIT;
      endcase
   end

   assign cmd_valid = (st_q != SQ_IDLE) && !wait_q && eng_ready;
   assign busy      = (st_q != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         wait_q  <= 1'b0;
         byte_q  <= '0;
         bit_q   <= '0;
         addr_q  <= '0;
         chan_q  <= '0;
         dummy_q <= 1'b0;
         rx_q    <= '0;
         abort_q <= 1'b0;
         fail_q  <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
         err_idx <= '0;
         rd_data <= '0;
      end else begin
         done <= 1'b0;
         if (st_q == SQ_IDLE) begin
            if (start_req) begin
               if ($onehot(chan_sel)) begin
                  st_q    <= SQ_START;
                  wait_q  <= 1'b0;
                  byte_q  <= '0;
                  bit_q   <= '0;
                  addr_q  <= dev_addr;
                  chan_q  <= chan_sel;
                  dummy_q <= dummy_ones;
                  rx_q    <= '0;
                  abort_q <= 1'b0;
               end else begin
                  done    <= 1'b1;
                  err     <= 1'b1;
                  err_idx <= REJECT_IDX;
               end
            end
         end else if (cmd_valid) begin
            wait_q <= 1'b1;
         end else if (sym_done) begin
            wait_q <= 1'b0;
            case (st_q)
               SQ_START: begin
                  st_q  <= SQ_BIT;
                  bit_q <= '0;
               end
               SQ_BIT: begin
                  if (!ack_slot) begin
                     if (is_rx) rx_q <= {rx_q[DATA_W-2:0], bit_in};
                     bit_q <= bit_q + 4'd1;
                  end else if (!is_rx && bit_in) begin
                     abort_q <= 1'b1;
                     fail_q  <= byte_q;
                     st_q    <= SQ_STOP;
                  end else if (byte_q == LAST_BYTE) begin
                     st_q <= SQ_STOP;
                  end else begin
                     byte_q <= byte_q + 3'd1;
                     bit_q  <= '0;
                     if (byte_q == RSTART_AT) st_q <= SQ_START;
                  end
               end
               default: begin
                  st_q    <= SQ_IDLE;
                  done    <= 1'b1;
                  err     <= abort_q;
                  err_idx <= abort_q ? fail_q : 3'd0;
                  if (!abort_q) rd_data <= rx_q;
               end
            endcase
         end
      end
   end

   // R6: malformed select answered next cycle without starting
   assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start_req && !$onehot(chan_sel)) |=> (done && err && err_idx == REJECT_IDX && !busy));

   // R9: a request during a transfer leaves the latched request alone
   assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_req) |=> ($stable(addr_q) && $stable(chan_q) && $stable(dummy_q)));

   // R10: completion never overlaps a transfer
   assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R10: result only moves with a completion pulse
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rd_data));

   // R7: a failed transfer keeps the previous result
   assert_keep_on_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> $stable(rd_data));
endmodule

// File: rtl/dac_rdbk_seq.sv
module dac_rdbk_seq
   import dac_rdbk_pkg::*;
#(
   parameter int unsigned CHAN_W      = 4,
   parameter logic [3:0]  RD_OPCODE   = 4'h9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start_req,
   input  logic [6:0]        dev_addr,
   input  logic [CHAN_W-1:0] chan_sel,
   input  logic              dummy_ones,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [2:0]        err_idx,
   output logic [15:0]       rd_data
);
   localparam int unsigned ADDR_W = 7;

   generate
      if (CHAN_W < 1 || CHAN_W > 4) begin : g_bad_chan
         $error("channel select must fit the low nibble of the command byte");
      end
      if (SYNC_STAGES > 4) begin : g_bad_sync
         $error("too many SDA sync stages for a four-tick bit");
      end
   endgenerate

   logic cmd_valid;
   sym_e cmd;
   logic bit_out;
   logic eng_ready;
   logic sym_done;
   logic bit_in;

   dac_rdbk_ctrl #(
      .CHAN_W   (CHAN_W),
      .RD_OPCODE(RD_OPCODE),
      .ADDR_W   (ADDR_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .dev_addr  (dev_addr),
      .chan_sel  (chan_sel),
      .dummy_ones(dummy_ones),
      .eng_ready (eng_ready),
      .sym_done  (sym_done),
      .bit_in    (bit_in),
      .cmd_valid (cmd_valid),
      .cmd       (cmd),
      .bit_out   (bit_out),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .err_idx   (err_idx),
      .rd_data   (rd_data)
   );

   i2c_sym_engine #(
      .SYNC_STAGES(SYNC_STAGES)
   ) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .cmd_valid(cmd_valid),
      .cmd      (cmd),
      .bit_out  (bit_out),
      .sda_i    (sda_i),
      .ready    (eng_ready),
      .sym_done (sym_done),
      .bit_in   (bit_in),
      .scl_oe   (scl_oe),
      .sda_oe   (sda_oe)
   );

   // R1: bus released whenever no transfer runs
   assert_idle_bus_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_dac_rdbk_seq.sv
module tb_dac_rdbk_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick;
   logic        start_req = 1'b0;
   logic [6:0]  dev_addr = '0;
   logic [3:0]  chan_sel = '0;
   logic        dummy_ones = 1'b0;
   logic        scl_oe, sda_oe, busy, done, err;
   logic [2:0]  err_idx;
   logic [15:0] rd_data;
   logic        scl, sda;
   logic        s_sda_oe = 1'b0;

   always #2.5 clk = !clk;

   logic [1:0] tdiv = '0;
   always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
   assign tick = (tdiv == 2'd3);

   assign scl = !scl_oe;
   assign sda = !(sda_oe || s_sda_oe);

   dac_rdbk_seq dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .start_req(start_req),
      .dev_addr(dev_addr), .chan_sel(chan_sel), .dummy_ones(dummy_ones),
      .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
      .done(done), .err(err), .err_idx(err_idx), .rd_data(rd_data)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // ---------------- slave model ----------------
   logic [15:0] regs [0:3];
   logic [7:0]  seen [0:7];
   logic [1:0]  mack_seen = 2'b00;
   int   s_bit = -1, s_byte = 0, s_rcnt = 0, nack_at = -1;
   int   n_start = 0, n_stop = 0, n_sclr = 0;
   logic [7:0] s_sh = '0;
   logic s_rd = 1'b0, s_rd_pend = 1'b0, s_first = 1'b0, s_mack = 1'b0;
   logic p_scl = 1'b1, p_sda = 1'b1;

   function automatic int ch2idx(input logic [3:0] c);
      if (c[1]) return 1;
      if (c[2]) return 2;
      if (c[3]) return 3;
      return 0;
   endfunction

   function automatic logic [7:0] rbyte();
      logic [15:0] v;
      v = regs[ch2idx(seen[1][3:0])];
      return (s_rcnt == 0) ? v[15:8] : v[7:0];
   endfunction

   always @(scl or sda) begin
      if (scl && p_scl && p_sda && !sda) begin
         n_start++; s_bit = -1; s_rd = 1'b0; s_rd_pend = 1'b0; s_first = 1'b1; s_sda_oe = 1'b0;
      end else if (scl && p_scl && !p_sda && sda) begin
         n_stop++; s_bit = -1; s_byte = 0; s_rd = 1'b0; s_rd_pend = 1'b0; s_sda_oe = 1'b0;
      end else if (scl && !p_scl) begin
         n_sclr++;
         if (s_bit >= 0 && s_bit < 8 && !s_rd) s_sh = {s_sh[6:0], sda};
         if (s_bit == 8 && s_rd) begin
            s_mack = sda;
            if (s_rcnt < 2) mack_seen[s_rcnt] = sda;
         end
      end else if (!scl && p_scl) begin
         s_bit++;
         if (s_bit == 8) begin
            if (!s_rd) begin
               if (s_byte < 8) seen[s_byte] = s_sh;
               s_sda_oe = (s_byte != nack_at);
               if (s_first && s_sh[0] && s_sda_oe) s_rd_pend = 1'b1;
            end else s_sda_oe = 1'b0;
         end else if (s_bit == 9) begin
            s_bit = 0; s_first = 1'b0;
            if (s_rd) begin
               s_rcnt++;
               if (s_mack) s_rd = 1'b0;
            end
            s_byte++;
            if (s_rd_pend) begin s_rd = 1'b1; s_rd_pend = 1'b0; s_rcnt = 0; end
         end
         if (s_bit >= 0 && s_bit < 8) s_sda_oe = s_rd ? !rbyte()[7 - s_bit] : 1'b0;
      end
      p_scl = scl; p_sda = sda;
   end

   // ---------------- scoreboard ----------------
   typedef struct { logic [15:0] data; logic err; logic [2:0] idx; } exp_t;
   exp_t sb[$];
   int   n_done = 0;
   logic [15:0] last_good = 16'h0000;

   always @(negedge clk) begin
      if (rst_n && done) begin
         n_done++;
         if (sb.size() == 0) chk(1'b0, "R10 unexpected done", 1, 0);
         else begin
            exp_t e;
            e = sb.pop_front();
            chk(rd_data == e.data, "R5/R7 rd_data", rd_data, e.data);
            chk(err == e.err, "R6/R7/R10 err", err, e.err);
            chk(err_idx == e.idx, "R6/R7 err_idx", err_idx, e.idx);
         end
      end
   end

   task automatic pulse_req(input logic [6:0] a, input logic [3:0] ch, input bit dum);
      @(negedge clk);
      dev_addr = a; chan_sel = ch; dummy_ones = dum; start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
   endtask

   task automatic do_read(input logic [6:0] a, input logic [3:0] ch, input bit dum,
                          input int nk, input bit poke);
      exp_t e;
      int s0, p0, r0, d0, exp_r;
      s0 = n_start; p0 = n_stop; r0 = n_sclr; d0 = n_done;
      nack_at = nk;
      if (nk < 0) begin e.data = regs[ch2idx(ch)]; e.err = 1'b0; e.idx = 3'd0; end
      else begin e.data = last_good; e.err = 1'b1; e.idx = 3'(nk); end
      sb.push_back(e);
      pulse_req(a, ch, dum);
      if (poke) begin
         repeat (200) @(negedge clk);
         chk(busy == 1'b1, "R9 busy during transfer", busy, 1);
         pulse_req(7'h55, 4'b0010, !dum);
      end
      while (n_done == d0) @(negedge clk);
      if (nk < 0) begin
         last_good = e.data;
         chk(seen[0] == {a, 1'b0}, "R2 write address byte", seen[0], {a, 1'b0});
         chk(seen[1] == {4'b1001, ch}, "R3 command byte", seen[1], {4'b1001, ch});
         chk(seen[2] == {8{dum}} && seen[3] == {8{dum}}, "R2 filler bytes", {seen[2], seen[3]}, {16{dum}});
         chk(seen[4] == {a, 1'b1}, "R4 read address byte", seen[4], {a, 1'b1});
         chk(n_start - s0 == 2 && n_stop - p0 == 1, "R4 start/stop count",
             (n_start - s0) * 16 + (n_stop - p0), 32'h21);
         chk(mack_seen == 2'b10, "R5 master ack then nack", mack_seen, 2'b10);
         exp_r = 66;
      end else begin
         chk(n_stop - p0 == 1, "R7 stop after missing ack", n_stop - p0, 1);
         exp_r = (nk == 4) ? 48 : 2 + 9 * (nk + 1);
      end
      chk(n_sclr - r0 == exp_r, "R8 SCL rising edges", n_sclr - r0, exp_r);
      chk(busy == 1'b0, "R9 busy low after stop", busy, 0);
      if (poke) begin
         repeat (40) @(negedge clk);
         chk(n_done == d0 + 1, "R9 request while busy ignored", n_done - d0, 1);
      end
      nack_at = -1;
   endtask

   task automatic do_reject(input logic [3:0] ch);
      exp_t e;
      int r0, s0, d0;
      r0 = n_sclr; s0 = n_start; d0 = n_done;
      e.data = last_good; e.err = 1'b1; e.idx = 3'd7;
      sb.push_back(e);
      pulse_req(7'h0C, ch, 1'b0);
      chk(busy == 1'b0, "R6 busy stays low", busy, 0);
      while (n_done == d0) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(n_sclr == r0 && n_start == s0, "R6 no bus activity", n_sclr - r0, 0);
   endtask

   // watchdog
   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] held;
      regs[0] = 16'h1234; regs[1] = 16'hBEEF; regs[2] = 16'hA5C3; regs[3] = 16'h0F81;
      for (int i = 0; i < 8; i++) seen[i] = 8'h00;
      repeat (5) @(negedge clk);
      chk(!busy && !done && !scl_oe && !sda_oe, "R1 reset state",
          {busy, done, scl_oe, sda_oe}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!busy && !scl_oe && !sda_oe, "R1 idle after reset", {busy, scl_oe, sda_oe}, 0);

      do_read(7'h0C, 4'b0100, 1'b0, -1, 1'b0);     // channel C, 0x94
      do_read(7'h0F, 4'b0001, 1'b1, -1, 1'b0);     // channel A, 0xFF filler
      do_read(7'h0C, 4'b1000, 1'b0, -1, 1'b0);     // channel D
      held = rd_data;
      repeat (50) @(negedge clk);
      chk(rd_data == held && !done, "R10 result held between pulses", rd_data, held);
      do_read(7'h0E, 4'b0010, 1'b1, -1, 1'b0);     // channel B

      do_reject(4'b0101);
      do_reject(4'b0000);

      do_read(7'h0C, 4'b0100, 1'b0, 0, 1'b0);
      do_read(7'h0C, 4'b0100, 1'b0, 1, 1'b0);
      do_read(7'h0C, 4'b0001, 1'b1, 3, 1'b0);
      do_read(7'h0C, 4'b1000, 1'b0, 4, 1'b0);

      do_read(7'h0C, 4'b0100, 1'b0, -1, 1'b0);     // R10 err cleared after success
      do_read(7'h0D, 4'b1000, 1'b1, -1, 1'b1);     // R9 request during transfer

      repeat (20) @(negedge clk);
      chk(sb.size() == 0, "R10 every expected completion seen", sb.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule